// File: doc/BRIEF.md
# Filtered Tamper Input Detector

This block watches a pair of tamper pins and keeps one sticky event flag per pin. Each pin is brought into the clock domain through a two-stage synchronizer. A shared filter setting chooses how a pin is judged. In edge mode the pin is judged on every clock, on a rising or falling transition. In level mode a scheduler judges the pin once per sampling period. That period is a power of two of an incoming prescaled tick. The pin must show its active level on a run of consecutive samples before the flag is set.

Before each level sample, the scheduler opens a short precharge window on a pull-up drive output. Software can switch this drive off while keeping the sample timing. A tamper event can also raise a one-cycle timestamp request. An enable gates the flags onto a level interrupt. Software clears a flag by writing 0 to its bit. An event that lands in the same cycle as that write wins.

Top module: `tamper_guard`

## Requirements
- R1: After reset `flags`, `irq`, `tsReq` and `pullUpEn` are all 0.
- R2: With `filtSel` = 0 (edge mode), an enabled source whose `trigSel` bit is 0 sets its flag on a rising pin transition, and with the bit at 1 on a falling transition; the opposite transition has no effect. The flag is visible after the third rising clock edge that follows the pin change.
- R3: With `filtSel` = 1, 2 or 3 (level mode), a source flags once 2, 4 or 8 consecutive samples show its active level: high when its `trigSel` bit is 0, low when it is 1. The flag appears on the sample that completes the run.
- R4: In level mode, a sample that does not show the active level returns the run count to zero.
- R5: Level samples are spaced 2^(15-`freqSel`) `tick` pulses apart. While `tick` is low, no sampling window opens.
- R6: Before each sample, `pullUpEn` is high for 2^`prchSel` consecutive clocks. This happens only when `prchOff` is 0 and level mode has at least one enabled source. With `prchOff` = 1 it stays low.
- R7: A source whose `srcEn` bit is 0 never sets its flag, and its run count is cleared. A flag already set stays set while the source is disabled.
- R8: A clock with `flagWr` high clears each flag whose `flagWrData` bit is 0 and keeps each flag whose bit is 1. An event in that same cycle leaves its flag set.
- R9: With `tsOnTamper` = 1, every event pulses `tsReq` high for one clock, in the cycle its flag is set. With `tsOnTamper` = 0, `tsReq` stays low.
- R10: `irq` is high exactly when `intEn` is 1 and at least one flag is set.
- R11: The two sources flag independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Prescaled tick that advances the sample divider |
| srcEn | input | 2 | Per-source enable |
| trigSel | input | 2 | Per-source trigger polarity (0: rising/high, 1: falling/low) |
| filtSel | input | 2 | 0 edge mode; 1, 2, 3 need 2, 4, 8 samples |
| freqSel | input | 3 | Sample period of 2^(15-freqSel) ticks |
| prchSel | input | 2 | Precharge window of 2^prchSel clocks |
| prchOff | input | 1 | Turns the pull-up drive off |
| tsOnTamper | input | 1 | Events also request a timestamp |
| intEn | input | 1 | Interrupt enable |
| tampPin | input | 2 | Asynchronous tamper pins |
| flagWr | input | 1 | Flag write strobe |
| flagWrData | input | 2 | Flag write data (0 clears) |
| flags | output | 2 | Sticky event flags |
| irq | output | 1 | Tamper interrupt |
| tsReq | output | 1 | One-cycle timestamp request |
| pullUpEn | output | 1 | Pull-up drive during precharge |

## Verification
The hardest situations to reach are a broken level run and a disable that falls between two samples. Both need pin changes placed against the free-running sample scheduler, which gives no direct timing output. The stimulus locks onto the scheduler by watching `pullUpEn` fall, because that marks the clock in which the sample is taken. It then changes a pin, or toggles `srcEn`, in the quiet span before the next window. The collision between a software clear and an edge event is reached the same way: the clear is placed on the third clock after the pin change.

// File: rtl/tamper_guard_pkg.sv
package tamper_guard_pkg;

  // strobes from the sample scheduler to the detection datapath
  typedef struct packed {
    logic prechActive;
    logic sampleNow;
  } schedStrobe_t;

  typedef enum logic [1:0] {
    SCHED_IDLE  = 2'd0,
    SCHED_PRECH = 2'd1,
    SCHED_SAMP  = 2'd2
  } schedState_t;

endpackage

// File: rtl/tamper_guard_ctrl.sv
module tamper_guard_ctrl
  import tamper_guard_pkg::*;
#(
  parameter int NUM_SRC      = 2,
  parameter int DIV_MAX_LOG2 = 15,
  parameter int FREQ_W       = 3,
  parameter int PRCH_W       = 2,
  parameter int FILT_W       = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick,
  input  logic [NUM_SRC-1:0] srcEn,
  input  logic [FILT_W-1:0]  filtSel,
  input  logic [FREQ_W-1:0]  freqSel,
  input  logic [PRCH_W-1:0]  prchSel,
  input  logic               prchOff,
  output schedStrobe_t       strobe,
  output logic               pullUpEn
);

  localparam int PRCH_CNT_W = 2 ** PRCH_W;

  logic [DIV_MAX_LOG2-1:0] divCnt;
  logic [DIV_MAX_LOG2-1:0] divMask;
  logic                    periodEnd;
  logic [PRCH_CNT_W-1:0]   prCnt;
  logic [PRCH_CNT_W-1:0]   prLoad;
  schedState_t             state;
  logic                    levelUse;

  // the divider wraps on the tick that fills the selected low bits
  assign divMask   = {DIV_MAX_LOG2{1'b1}} >> freqSel;
  assign periodEnd = tick && ((divCnt & divMask) == divMask);
  assign prLoad    = (PRCH_CNT_W'(1) << prchSel) - PRCH_CNT_W'(1);
  assign levelUse  = (filtSel != '0) && (srcEn != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (tick) begin
      divCnt <= divCnt + DIV_MAX_LOG2'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= SCHED_IDLE;
      prCnt <= '0;
    end else begin
      case (state)
        SCHED_IDLE: begin
          if (periodEnd) begin
            state <= SCHED_PRECH;
            prCnt <= prLoad;
          end
        end
        SCHED_PRECH: begin
          if (prCnt == '0) begin
            state <= SCHED_SAMP;
          end else begin
            prCnt <= prCnt - PRCH_CNT_W'(1);
          end
        end
        default: state <= SCHED_IDLE;
      endcase
    end
  end

  assign strobe.prechActive = (state == SCHED_PRECH);
  assign strobe.sampleNow   = (state == SCHED_SAMP);
  assign pullUpEn           = strobe.prechActive && !prchOff && levelUse;

endmodule

// File: rtl/tamper_guard_dp.sv
module tamper_guard_dp
  import tamper_guard_pkg::*;
#(
  parameter int NUM_SRC     = 2,
  parameter int FILT_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  schedStrobe_t       strobe,
  input  logic [NUM_SRC-1:0] srcEn,
  input  logic [NUM_SRC-1:0] trigSel,
  input  logic [FILT_W-1:0]  filtSel,
  input  logic               tsOnTamper,
  input  logic               intEn,
  input  logic [NUM_SRC-1:0] tampPin,
  input  logic               flagWr,
  input  logic [NUM_SRC-1:0] flagWrData,
  output logic [NUM_SRC-1:0] flags,
  output logic               irq,
  output logic               tsReq
);

  localparam int RUN_W = 2 ** FILT_W;

  logic [NUM_SRC-1:0] syncQ [SYNC_STAGES];
  logic [NUM_SRC-1:0] pinS;
  logic [NUM_SRC-1:0] pinPrev;
  logic [NUM_SRC-1:0] hit;
  logic [NUM_SRC-1:0] clrMask;
  logic [RUN_W-1:0]   need;
  logic               edgeMode;

  assign edgeMode = (filtSel == '0);
  assign need     = RUN_W'(1) << filtSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ[0] <= '0;
    end else begin
      syncQ[0] <= tampPin;
    end
  end

  for (genvar st = 1; st < SYNC_STAGES; st++) begin : gSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ[st] <= '0;
      end else begin
        syncQ[st] <= syncQ[st-1];
      end
    end
  end

  assign pinS = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinPrev <= '0;
    end else begin
      pinPrev <= pinS;
    end
  end

  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : gSrc
    logic             rise;
    logic             fall;
    logic             edgeHit;
    logic             levelMatch;
    logic             runDone;
    logic [RUN_W-1:0] runCnt;

    assign rise       = pinS[gi] && !pinPrev[gi];
    assign fall       = !pinS[gi] && pinPrev[gi];
    assign edgeHit    = trigSel[gi] ? fall : rise;
    assign levelMatch = trigSel[gi] ? !pinS[gi] : pinS[gi];
    assign runDone    = ({1'b0, runCnt} + (RUN_W + 1)'(1)) >= {1'b0, need};

    always_comb begin
      if (!srcEn[gi]) begin
        hit[gi] = 1'b0;
      end else if (edgeMode) begin
        hit[gi] = edgeHit;
      end else begin
        hit[gi] = strobe.sampleNow && levelMatch && runDone;
      end
    end

    // consecutive-sample counter, saturating at the needed run
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        runCnt <= '0;
      end else if (!srcEn[gi] || edgeMode) begin
        runCnt <= '0;
      end else if (strobe.sampleNow) begin
        if (!levelMatch) begin
          runCnt <= '0;
        end else if (!runDone) begin
          runCnt <= runCnt + RUN_W'(1);
        end
      end
    end
  end

  assign clrMask = flagWr ? ~flagWrData : '0;

  // a same-cycle event overrides the software clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags <= '0;
      tsReq <= 1'b0;
    end else begin
      flags <= (flags & ~clrMask) | hit;
      tsReq <= tsOnTamper && (hit != '0);
    end
  end

  assign irq = intEn && (flags != '0);

endmodule

// File: rtl/tamper_guard.sv
module tamper_guard
  import tamper_guard_pkg::*;
#(
  parameter int NUM_SRC      = 2,
  parameter int DIV_MAX_LOG2 = 15,
  parameter int FREQ_W       = 3,
  parameter int PRCH_W       = 2,
  parameter int FILT_W       = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick,
  input  logic [NUM_SRC-1:0] srcEn,
  input  logic [NUM_SRC-1:0] trigSel,
  input  logic [FILT_W-1:0]  filtSel,
  input  logic [FREQ_W-1:0]  freqSel,
  input  logic [PRCH_W-1:0]  prchSel,
  input  logic               prchOff,
  input  logic               tsOnTamper,
  input  logic               intEn,
  input  logic [NUM_SRC-1:0] tampPin,
  input  logic               flagWr,
  input  logic [NUM_SRC-1:0] flagWrData,
  output logic [NUM_SRC-1:0] flags,
  output logic               irq,
  output logic               tsReq,
  output logic               pullUpEn
);

  schedStrobe_t strobe;

  tamper_guard_ctrl #(
    .NUM_SRC(NUM_SRC), .DIV_MAX_LOG2(DIV_MAX_LOG2), .FREQ_W(FREQ_W),
    .PRCH_W(PRCH_W), .FILT_W(FILT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .srcEn(srcEn), .filtSel(filtSel),
    .freqSel(freqSel), .prchSel(prchSel), .prchOff(prchOff),
    .strobe(strobe), .pullUpEn(pullUpEn)
  );

  tamper_guard_dp #(
    .NUM_SRC(NUM_SRC), .FILT_W(FILT_W), .SYNC_STAGES(2)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .srcEn(srcEn), .trigSel(trigSel),
    .filtSel(filtSel), .tsOnTamper(tsOnTamper), .intEn(intEn),
    .tampPin(tampPin), .flagWr(flagWr), .flagWrData(flagWrData),
    .flags(flags), .irq(irq), .tsReq(tsReq)
  );

endmodule

// File: rtl/tamper_guard_chk.sv
module tamper_guard_chk #(
  parameter int NUM_SRC = 2,
  parameter int PRCH_W  = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] srcEn,
  input logic               tsOnTamper,
  input logic               flagWr,
  input logic [NUM_SRC-1:0] flagWrData,
  input logic [NUM_SRC-1:0] flags,
  input logic               tsReq,
  input logic               pullUpEn
);

  localparam int PR_MAX = 2 ** (2 ** PRCH_W - 1);

  logic [7:0] pullRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pullRun <= '0;
    end else if (!pullUpEn) begin
      pullRun <= '0;
    end else if (pullRun != 8'hFF) begin
      pullRun <= pullRun + 8'd1;
    end
  end

  // R6: the precharge drive never outlasts the longest window
  assert_prech_window_R6: assert property (@(posedge clk) disable iff (!rstN)
    int'(pullRun) <= PR_MAX);

  // R9: a timestamp request only follows an enabled mode and a fresh flag
  assert_ts_mode_R9: assert property (@(posedge clk) disable iff (!rstN)
    tsReq |-> $past(tsOnTamper));

  assert_ts_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    tsReq |-> (flags != '0));

  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : gFlag
    // R7: a flag can only rise while its source was enabled
    assert_rise_enabled_R7: assert property (@(posedge clk) disable iff (!rstN)
      $rose(flags[gi]) |-> $past(srcEn[gi]));

    // R8: a flag only falls through a software write of 0
    assert_fall_by_write_R8: assert property (@(posedge clk) disable iff (!rstN)
      $fell(flags[gi]) |-> $past(flagWr && !flagWrData[gi]));
  end

endmodule

bind tamper_guard tamper_guard_chk #(.NUM_SRC(NUM_SRC), .PRCH_W(PRCH_W)) u_chk (
  .clk(clk), .rstN(rstN), .srcEn(srcEn), .tsOnTamper(tsOnTamper),
  .flagWr(flagWr), .flagWrData(flagWrData), .flags(flags),
  .tsReq(tsReq), .pullUpEn(pullUpEn)
);

// File: tb/tb_tamper_guard.sv
`timescale 1ns/1ps
module tb_tamper_guard;

  logic       clk = 1'b0;
  logic       rstN;
  logic       tick;
  logic [1:0] srcEn, trigSel, filtSel, prchSel, tampPin, flagWrData, flags;
  logic [2:0] freqSel;
  logic       prchOff, tsOnTamper, intEn, flagWr, irq, tsReq, pullUpEn;

  always #4 clk = ~clk;

  tamper_guard dut (
    .clk(clk), .rstN(rstN), .tick(tick), .srcEn(srcEn), .trigSel(trigSel),
    .filtSel(filtSel), .freqSel(freqSel), .prchSel(prchSel), .prchOff(prchOff),
    .tsOnTamper(tsOnTamper), .intEn(intEn), .tampPin(tampPin),
    .flagWr(flagWr), .flagWrData(flagWrData), .flags(flags), .irq(irq),
    .tsReq(tsReq), .pullUpEn(pullUpEn)
  );

  // port vector: bit0-1 flags, bit2 pullUpEn, bit3 tsReq, bit4 irq
  typedef struct {
    string req;
    int    kind;
    int    exp;
    int    mask;
  } item_t;

  item_t sbq[$];
  int    measVal;
  event  obsEv;
  int    nCmp = 0;
  int    nBad = 0;
  bit    done = 1'b0;

  // monitor: pops expected items and compares against the design
  initial begin
    forever begin
      @(obsEv);
      while (sbq.size() > 0) begin
        item_t it;
        int    act;
        it  = sbq.pop_front();
        act = (it.kind == 0) ? ({27'd0, irq, tsReq, pullUpEn, flags} & it.mask) : measVal;
        nCmp++;
        if (act != it.exp) begin
          nBad++;
          $display("FAIL %s actual=%0h expected=%0h", it.req, act, it.exp);
        end
      end
    end
  end

  task automatic expectPorts(input string req, input int mask, input int exp);
    #1;
    sbq.push_back('{req, 0, exp, mask});
    -> obsEv;
    #1;
  endtask

  task automatic expectCount(input string req, input int exp, input int meas);
    #1;
    measVal = meas;
    sbq.push_back('{req, 1, exp, 0});
    -> obsEv;
    #1;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // returns at the negedge right after a level sample was taken
  task automatic waitSample();
    do @(negedge clk); while (!pullUpEn);
    do @(negedge clk); while (pullUpEn);
    @(negedge clk);
  endtask

  task automatic measureWidth(output int w);
    w = 0;
    do @(negedge clk); while (pullUpEn);
    do @(negedge clk); while (!pullUpEn);
    while (pullUpEn) begin
      w++;
      @(negedge clk);
    end
  endtask

  task automatic measurePeriod(output int p);
    p = 0;
    do @(negedge clk); while (pullUpEn);
    do @(negedge clk); while (!pullUpEn);
    do begin
      @(negedge clk);
      p++;
    end while (pullUpEn);
    do begin
      @(negedge clk);
      p++;
    end while (!pullUpEn);
  endtask

  task automatic countHigh(input int n, output int c);
    c = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (pullUpEn) c++;
    end
  endtask

  task automatic clearAll();
    flagWr = 1'b1;
    flagWrData = 2'b00;
    @(negedge clk);
    flagWr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nCmp++;
      nBad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    int w;
    rstN = 1'b0; tick = 1'b1; srcEn = 2'b00; trigSel = 2'b00; filtSel = 2'b00;
    freqSel = 3'd7; prchSel = 2'd0; prchOff = 1'b0; tsOnTamper = 1'b0;
    intEn = 1'b0; tampPin = 2'b10; flagWr = 1'b0; flagWrData = 2'b00;
    cyc(3);
    rstN = 1'b1;
    @(negedge clk);
    expectPorts("R1 reset state", 31, 0);

    // R2 rising edge on source 0, exact latency
    srcEn = 2'b01;
    cyc(2);
    tampPin[0] = 1'b1;
    cyc(2);
    expectPorts("R2 no flag before third edge", 3, 0);
    cyc(1);
    expectPorts("R2 rising edge flag, R10 irq masked", 31, 1);
    intEn = 1'b1;
    expectPorts("R10 irq with flag", 16, 16);

    // R2 falling edge on source 1, R11 independence
    trigSel = 2'b10; srcEn = 2'b11;
    cyc(2);
    tampPin[1] = 1'b0;
    cyc(3);
    expectPorts("R2 falling edge / R11", 3, 3);

    // R8 partial clear
    flagWr = 1'b1; flagWrData = 2'b10;
    @(negedge clk);
    flagWr = 1'b0;
    expectPorts("R8 clear bit0 keep bit1", 3, 2);

    // R2 opposite edge ignored
    tampPin[0] = 1'b0;
    cyc(4);
    expectPorts("R2 falling ignored in rising mode", 3, 2);

    // R9 timestamp pulse
    tsOnTamper = 1'b1;
    tampPin[0] = 1'b1;
    cyc(3);
    expectPorts("R9 tsReq with flag", 11, 11);
    cyc(1);
    expectPorts("R9 tsReq single cycle", 8, 0);

    // R8 event wins over same-cycle clear
    tampPin[0] = 1'b0;
    cyc(4);
    flagWr = 1'b1; flagWrData = 2'b10;
    @(negedge clk);
    flagWr = 1'b0;
    tampPin[0] = 1'b1;
    cyc(2);
    flagWr = 1'b1; flagWrData = 2'b00;
    @(negedge clk);
    flagWr = 1'b0;
    expectPorts("R8 event beats clear", 3, 1);

    // R7 disabled sources, existing flag kept
    srcEn = 2'b00; tsOnTamper = 1'b0;
    cyc(2);
    tampPin[1] = 1'b1;
    cyc(3);
    tampPin[1] = 1'b0;
    cyc(4);
    expectPorts("R7 disabled ignores edge, flag held", 3, 1);
    clearAll();
    expectPorts("R8 clear all / R10 irq low", 31, 0);

    // R3 level mode, two high samples
    intEn = 1'b0; filtSel = 2'd1; freqSel = 3'd7; prchSel = 2'd0;
    trigSel = 2'b00; srcEn = 2'b01; tampPin = 2'b10;
    waitSample();
    tampPin[0] = 1'b1;
    waitSample();
    expectPorts("R3 one sample not enough", 3, 0);
    waitSample();
    expectPorts("R3 two samples flag", 3, 1);
    clearAll();

    // R4 run broken by mismatch, low-active four-sample filter
    filtSel = 2'd2; trigSel = 2'b01;
    waitSample();
    tampPin[0] = 1'b0;
    waitSample(); waitSample(); waitSample();
    expectPorts("R3 three of four samples", 3, 0);
    tampPin[0] = 1'b1;
    waitSample();
    tampPin[0] = 1'b0;
    waitSample(); waitSample(); waitSample();
    expectPorts("R4 run restarted after mismatch", 3, 0);
    waitSample();
    expectPorts("R3 four samples flag", 3, 1);

    // R6 precharge widths
    prchSel = 2'd3;
    measureWidth(w);
    measureWidth(w);
    expectCount("R6 precharge width 8", 8, w);
    prchSel = 2'd0;
    measureWidth(w);
    measureWidth(w);
    expectCount("R6 precharge width 1", 1, w);

    // R5 sample period
    measurePeriod(w);
    expectCount("R5 period 256 ticks", 256, w);
    freqSel = 3'd6;
    measurePeriod(w);
    measurePeriod(w);
    expectCount("R5 period 512 ticks", 512, w);

    // R5 tick held low
    do @(negedge clk); while (!pullUpEn);
    do @(negedge clk); while (pullUpEn);
    tick = 1'b0;
    countHigh(1200, w);
    expectCount("R5 no window without tick", 0, w);
    tick = 1'b1;

    // R6 precharge turned off
    freqSel = 3'd7; prchOff = 1'b1;
    countHigh(1200, w);
    expectCount("R6 pull-up off", 0, w);
    prchOff = 1'b0;

    // R7 disable clears run count
    clearAll();
    filtSel = 2'd1; trigSel = 2'b10; srcEn = 2'b11; tampPin = 2'b10;
    waitSample();
    tampPin[0] = 1'b1;
    waitSample();
    srcEn = 2'b10;
    cyc(3);
    srcEn = 2'b11;
    waitSample();
    expectPorts("R7 run cleared by disable", 3, 0);
    waitSample();
    expectPorts("R3 flag after fresh run", 3, 1);

    done = 1'b1;
    cyc(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule